// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A caller presents the virtual address, the physical base of the top-level table, the kind of access (read, write or execute), the privilege mode, the make-executable-readable flag, the supervisor-may-touch-user-pages flag and an incoming global flag. The walker then fetches 4-byte page table entries one at a time over a simple request/response memory port.

Each level consumes a 10-bit slice of the virtual page number. A pointer entry at the top level leads to a second table. A leaf entry at the top level maps a 4 MiB superpage, which must be aligned. A leaf at the bottom level maps a 4 KiB page. The walk ends with a one-cycle `done` pulse. On success the pulse carries the physical address, the leaf entry, its address, the level and the accumulated global flag. On failure it carries a fault code instead.

Page table entry layout: bit 0 V (valid), bit 1 R, bit 2 W, bit 3 X, bit 4 U (user), bit 5 G (global), bits 7:6 are carried but ignored, bits 31:10 are the 22-bit physical page number (PPN).

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to `req_root + {vaddr[31:22], 2'b00}`. Level 1 is the top level.
- R2: A pointer entry (V=1, R=W=X=0) found at level 1 makes the second read go to `{PPN, 12'h000} + {vaddr[21:12], 2'b00}` at level 0.
- R3: A read answered with `mem_rsp_err=1` ends the walk with fault code 1 (access).
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with fault code 2 (invalid). A pointer entry at level 0 also gives code 2.
- R5: A permitted leaf at level 1 whose PPN bits 9:0 are not all zero ends the walk with fault code 3 (misaligned superpage).
- R6: A leaf that fails the permission check ends the walk with fault code 4. This check takes priority over the misalignment check. Access encoding: 0 read, 1 write, 2 execute, 3 always denied. A read needs R, or X when the make-readable flag is set. A write needs W. An execute needs X. When `req_priv`=0 (user), the page must have U=1. When `req_priv`=1 (supervisor), a U=1 page is refused unless the supervisor-user flag is set, and it is always refused for execute.
- R7: On success, the physical address is `{PPN, vaddr[11:0]}` at level 0. At level 1 it is `{PPN[21:10], vaddr[21:0]}`. The leaf entry, its address and the level are reported alongside.
- R8: The reported global flag is the OR of `req_global` and the G bit of every entry read in the walk.
- R9: `mem_req_valid` is high for exactly one cycle per entry read. No new read is issued until the previous one has been answered. `busy` is high from the cycle after acceptance until the walk ends. A request is accepted only while `busy` is low.
- R10: `done` is high for exactly one cycle per walk. At that cycle `fault` is 1 exactly when `fault_code` is nonzero (0 means success). After reset `done`, `busy` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when `busy` is low) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 34 | Physical base of the top-level table |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_priv | input | 1 | 1 supervisor, 0 user |
| req_mxr | input | 1 | Let executable pages satisfy reads |
| req_sum | input | 1 | Let supervisor mode access user pages |
| req_global | input | 1 | Incoming global flag |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request (one cycle) |
| mem_req_addr | output | 34 | Physical address of the entry read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Entry returned by memory |
| mem_rsp_err | input | 1 | Bus error on the read |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | 0 none, 1 access, 2 invalid, 3 misaligned, 4 permission |
| res_paddr | output | 34 | Translated physical address |
| res_pte | output | 32 | Leaf entry |
| res_pte_addr | output | 34 | Address the leaf entry was read from |
| res_level | output | 1 | Level at which the leaf was found |
| res_global | output | 1 | Accumulated global flag |

## Verification
Directed walks cover each outcome on its own:
- An aligned superpage, a misaligned one, and a misaligned one that also lacks permission. This last case tells whether permission wins over alignment.
- A pointer followed by a level-0 leaf, a pointer at level 0, and a bus error on the second read.
- The two invalid encodings.
- Each user/supervisor and make-readable combination.

Random walks then mix pointers and leaves, random flags, superpages with and without aligned PPNs, random access kinds and response latencies. The first-read and second-read addresses are compared on every read. This separates a wrong slice of the virtual page number from a wrong table base. The full result is compared against a reference computed in the bench.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ACCESS   = 3'd1,
      FLT_INVALID  = 3'd2,
      FLT_MISALIGN = 3'd3,
      FLT_PERM     = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_st_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
   parameter int PTE_W = 32,
   parameter int PPN_W = 22
) (
   input  logic [PTE_W-1:0] pte,
   output logic             bit_r,
   output logic             bit_w,
   output logic             bit_x,
   output logic             bit_u,
   output logic             bit_g,
   output logic             is_bad,
   output logic             is_ptr,
   output logic [PPN_W-1:0] ppn
);
   localparam int PPN_LSB = PTE_W - PPN_W;

   logic bit_v;

   always_comb begin
      bit_v  = pte[0];
      bit_r  = pte[1];
      bit_w  = pte[2];
      bit_x  = pte[3];
      bit_u  = pte[4];
      bit_g  = pte[5];
      ppn    = pte[PTE_W-1:PPN_LSB];
      is_bad = !bit_v || (bit_w && !bit_r);
      is_ptr = !is_bad && !bit_r && !bit_w && !bit_x;
   end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
(
   input  acc_e acc,
   input  logic priv_sup,
   input  logic mxr,
   input  logic sum,
   input  logic bit_r,
   input  logic bit_w,
   input  logic bit_x,
   input  logic bit_u,
   output logic allow
);
   logic mode_ok;
   logic kind_ok;

   always_comb begin
      if (priv_sup) mode_ok = !bit_u || (sum && acc != ACC_EXEC);
      else          mode_ok = bit_u;

      unique case (acc)
         ACC_READ:  kind_ok = bit_r || (mxr && bit_x);
         ACC_WRITE: kind_ok = bit_w;
         ACC_EXEC:  kind_ok = bit_x;
         default:   kind_ok = 1'b0;
      endcase

      allow = mode_ok && kind_ok;
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter  int VA_W      = 32,
   parameter  int LVL_BITS  = 10,
   parameter  int LEVELS    = 2,
   parameter  int OFS_BITS  = 12,
   parameter  int PPN_W     = 22,
   parameter  int PTE_W     = 32,
   parameter  int PTE_LOG   = 2,
   localparam int PA_W      = PPN_W + OFS_BITS,
   localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  req_root,
   input  logic [1:0]       req_acc,
   input  logic             req_priv,
   input  logic             req_mxr,
   input  logic             req_sum,
   input  logic             req_global,
   output logic             busy,
   output logic             mem_req_valid,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   input  logic             mem_rsp_err,
   output logic             done,
   output logic             fault,
   output logic [2:0]       fault_code,
   output logic [PA_W-1:0]  res_paddr,
   output logic [PTE_W-1:0] res_pte,
   output logic [PA_W-1:0]  res_pte_addr,
   output logic [LVL_W-1:0] res_level,
   output logic             res_global
);
   localparam int VPN_W = LEVELS * LVL_BITS;

   // elaboration-time parameter checks
   if (VA_W != OFS_BITS + VPN_W) begin : g_bad_va
      $error("VA_W must equal OFS_BITS + LEVELS*LVL_BITS");
   end
   if (PPN_W < VPN_W) begin : g_bad_ppn
      $error("PPN_W must cover the virtual page number");
   end
   if (PTE_W - PPN_W < 6) begin : g_bad_pte
      $error("PTE_W leaves no room for the flag bits");
   end

   walk_st_e         st_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PA_W-1:0]  base_q;
   logic [VA_W-1:0]  va_q;
   acc_e             acc_q;
   logic             priv_q, mxr_q, sum_q, glob_q;

   logic [LVL_BITS-1:0] idx;
   logic [PA_W-1:0]     pte_addr;

   always_comb begin
      idx      = va_q[OFS_BITS + int'(lvl_q) * LVL_BITS +: LVL_BITS];
      pte_addr = base_q + PA_W'({idx, {PTE_LOG{1'b0}}});
   end

   logic             d_r, d_w, d_x, d_u, d_g, d_bad, d_ptr;
   logic [PPN_W-1:0] d_ppn;

   ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
      .pte    (mem_rsp_data),
      .bit_r  (d_r),
      .bit_w  (d_w),
      .bit_x  (d_x),
      .bit_u  (d_u),
      .bit_g  (d_g),
      .is_bad (d_bad),
      .is_ptr (d_ptr),
      .ppn    (d_ppn)
   );

   logic perm_ok;

   ptw_perm_check u_perm (
      .acc      (acc_q),
      .priv_sup (priv_q),
      .mxr      (mxr_q),
      .sum      (sum_q),
      .bit_r    (d_r),
      .bit_w    (d_w),
      .bit_x    (d_x),
      .bit_u    (d_u),
      .allow    (perm_ok)
   );

   // superpage handling: bits below the leaf level come from the VPN
   logic [PPN_W-1:0] lvl_mask, vpn_ext, ppn_merged;
   logic             misal;

   always_comb begin
      lvl_mask   = (PPN_W'(1) << (int'(lvl_q) * LVL_BITS)) - PPN_W'(1);
      vpn_ext    = PPN_W'(va_q[VA_W-1:OFS_BITS]);
      misal      = |(d_ppn & lvl_mask);
      ppn_merged = (d_ppn & ~lvl_mask) | (vpn_ext & lvl_mask);
   end

   logic   step_fin, step_down;
   fault_e step_code;

   always_comb begin
      step_fin  = 1'b0;
      step_down = 1'b0;
      step_code = FLT_NONE;
      if (st_q == ST_WAIT && mem_rsp_valid) begin
         step_fin = 1'b1;
         if (mem_rsp_err)             step_code = FLT_ACCESS;
         else if (d_bad)              step_code = FLT_INVALID;
         else if (d_ptr) begin
            if (lvl_q != '0) begin
               step_fin  = 1'b0;
               step_down = 1'b1;
            end else begin
               step_code = FLT_INVALID;
            end
         end
         else if (!perm_ok)           step_code = FLT_PERM;
         else if (lvl_q != '0 && misal) step_code = FLT_MISALIGN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         lvl_q        <= '0;
         base_q       <= '0;
         va_q         <= '0;
         acc_q        <= ACC_READ;
         priv_q       <= 1'b0;
         mxr_q        <= 1'b0;
         sum_q        <= 1'b0;
         glob_q       <= 1'b0;
         done         <= 1'b0;
         fault        <= 1'b0;
         fault_code   <= FLT_NONE;
         res_paddr    <= '0;
         res_pte      <= '0;
         res_pte_addr <= '0;
         res_level    <= '0;
         res_global   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= req_root;
                  acc_q  <= acc_e'(req_acc);
                  priv_q <= req_priv;
                  mxr_q  <= req_mxr;
                  sum_q  <= req_sum;
                  glob_q <= req_global;
                  lvl_q  <= LVL_W'(LEVELS - 1);
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (step_down) begin
                  base_q <= {d_ppn, {OFS_BITS{1'b0}}};
                  lvl_q  <= lvl_q - LVL_W'(1);
                  glob_q <= glob_q | d_g;
                  st_q   <= ST_ISSUE;
               end else if (step_fin) begin
                  done         <= 1'b1;
                  fault        <= (step_code != FLT_NONE);
                  fault_code   <= step_code;
                  res_paddr    <= (step_code == FLT_NONE) ?
                                  {ppn_merged, va_q[OFS_BITS-1:0]} : '0;
                  res_pte      <= mem_rsp_data;
                  res_pte_addr <= pte_addr;
                  res_level    <= lvl_q;
                  res_global   <= glob_q | d_g;
                  st_q         <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (st_q != ST_IDLE);
   assign mem_req_valid = (st_q == ST_ISSUE);
   assign mem_req_addr  = pte_addr;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 34,
   parameter int PTE_W    = 32,
   parameter int OFS_BITS = 12,
   parameter int LVL_BITS = 10,
   parameter int LVL_W    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_vaddr,
   input logic             busy,
   input logic             mem_req_valid,
   input logic             mem_rsp_valid,
   input logic             done,
   input logic             fault,
   input logic [PA_W-1:0]  res_paddr,
   input logic [PTE_W-1:0] res_pte,
   input logic [LVL_W-1:0] res_level,
   input logic             res_global
);
   logic [VA_W-1:0] cap_va;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cap_va <= '0;
      else if (req_valid && !busy) cap_va <= req_vaddr;
   end

   // R9: one-cycle read request, only inside a walk
   p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   p_req_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);
   p_rsp_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> busy);

   // R10: done is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: page offset passes through; superpage merges the low VPN slice
   p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> res_paddr[OFS_BITS-1:0] == cap_va[OFS_BITS-1:0]);
   p_super_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && res_level != '0) |->
         res_paddr[OFS_BITS +: LVL_BITS] == cap_va[OFS_BITS +: LVL_BITS]);
   p_leaf_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> res_pte[0]);

   // R8: a global leaf yields a global result
   p_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && res_pte[5]) |-> res_global);
endmodule

bind pt_walker ptw_checker #(
   .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
   .OFS_BITS(OFS_BITS), .LVL_BITS(LVL_BITS), .LVL_W(LVL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_vaddr     (req_vaddr),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .mem_rsp_valid (mem_rsp_valid),
   .done          (done),
   .fault         (fault),
   .res_paddr     (res_paddr),
   .res_pte       (res_pte),
   .res_level     (res_level),
   .res_global    (res_global)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [33:0] req_root = '0;
   logic [1:0]  req_acc = '0;
   logic        req_priv = 1'b0, req_mxr = 1'b0, req_sum = 1'b0, req_global = 1'b0;
   logic        busy, mem_req_valid;
   logic [33:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        done, fault;
   logic [2:0]  fault_code;
   logic [33:0] res_paddr, res_pte_addr;
   logic [31:0] res_pte;
   logic [0:0]  res_level;
   logic        res_global;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_root(req_root), .req_acc(req_acc), .req_priv(req_priv),
      .req_mxr(req_mxr), .req_sum(req_sum), .req_global(req_global),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_err(mem_rsp_err), .done(done), .fault(fault),
      .fault_code(fault_code), .res_paddr(res_paddr), .res_pte(res_pte),
      .res_pte_addr(res_pte_addr), .res_level(res_level), .res_global(res_global)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit perm_ref(input logic [7:0] f, input logic [1:0] acc,
                                   input bit sup, input bit mxr, input bit sum);
      bit kind, mode;
      case (acc)
         2'd0: kind = f[1] | (mxr & f[3]);
         2'd1: kind = f[2];
         2'd2: kind = f[3];
         default: kind = 1'b0;
      endcase
      if (!sup) mode = f[4];
      else if (f[4]) mode = sum && (acc != 2'd2);
      else mode = 1'b1;
      return kind && mode;
   endfunction

   function automatic bit bad_ref(input logic [31:0] p);
      return !p[0] || (p[2] && !p[1]);
   endfunction

   function automatic bit ptr_ref(input logic [31:0] p);
      return p[0] && p[3:1] == 3'b000;
   endfunction

   // reference walk
   task automatic model(input logic [31:0] va, input logic [33:0] root,
                        input logic [1:0] acc, input bit sup, input bit mxr,
                        input bit sum, input bit gin,
                        input logic [31:0] p1, input bit e1,
                        input logic [31:0] p0, input bit e0,
                        output logic [2:0] code, output logic [33:0] pa,
                        output logic [33:0] pa_pte, output bit lvl,
                        output bit glob, output int nrd,
                        output logic [33:0] a1, output logic [33:0] a0);
      a1 = root + {22'd0, va[31:22], 2'b00};
      a0 = {p1[31:10], 12'h000} + {22'd0, va[21:12], 2'b00};
      pa = '0; pa_pte = a1; lvl = 1'b1; glob = gin | p1[5]; nrd = 1; code = 3'd0;
      if (e1) code = 3'd1;
      else if (bad_ref(p1)) code = 3'd2;
      else if (ptr_ref(p1)) begin
         nrd = 2; lvl = 1'b0; pa_pte = a0; glob = glob | p0[5];
         if (e0) code = 3'd1;
         else if (bad_ref(p0) || ptr_ref(p0)) code = 3'd2;
         else if (!perm_ref(p0[7:0], acc, sup, mxr, sum)) code = 3'd4;
         else pa = {p0[31:10], va[11:0]};
      end
      else if (!perm_ref(p1[7:0], acc, sup, mxr, sum)) code = 3'd4;
      else if (p1[19:10] != 10'd0) code = 3'd3;
      else pa = {p1[31:20], va[21:0]};
   endtask

   task automatic run_case(input logic [31:0] va, input logic [33:0] root,
                           input logic [1:0] acc, input bit sup, input bit mxr,
                           input bit sum, input bit gin,
                           input logic [31:0] p1, input bit e1,
                           input logic [31:0] p0, input bit e0,
                           input string name);
      logic [2:0]  e_code;
      logic [33:0] e_pa, e_pte_addr, a1, a0;
      bit          e_lvl, e_glob, seen_done;
      int          e_nrd, nrd;
      model(va, root, acc, sup, mxr, sum, gin, p1, e1, p0, e0,
            e_code, e_pa, e_pte_addr, e_lvl, e_glob, e_nrd, a1, a0);
      @(negedge clk);
      req_vaddr = va; req_root = root; req_acc = acc; req_priv = sup;
      req_mxr = mxr; req_sum = sum; req_global = gin; req_valid = 1'b1;
      nrd = 0; seen_done = 1'b0;
      for (int it = 0; it < 100 && !seen_done; it++) begin
         @(negedge clk);
         req_valid = 1'b0;
         mem_rsp_valid = 1'b0;
         if (done) begin
            seen_done = 1'b1;
         end else if (mem_req_valid) begin
            // R1 / R2: entry addresses
            if (nrd == 0) chk(mem_req_addr == a1, {"R1 first read addr ", name}, 64'(mem_req_addr), 64'(a1));
            else          chk(mem_req_addr == a0, {"R2 second read addr ", name}, 64'(mem_req_addr), 64'(a0));
            for (int k = 0; k < 1 + int'($urandom % 3); k++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (nrd == 0) ? p1 : p0;
            mem_rsp_err   = (nrd == 0) ? e1 : e0;
            nrd++;
         end
      end
      mem_rsp_valid = 1'b0;
      chk(seen_done, {"R10 done seen ", name}, 64'(seen_done), 64'd1);
      if (!seen_done) return;
      chk(nrd == e_nrd, {"R9 read count ", name}, 64'(nrd), 64'(e_nrd));
      chk(fault_code == e_code, {"R3 R4 R5 R6 fault code ", name}, 64'(fault_code), 64'(e_code));
      chk(fault == (e_code != 3'd0), {"R10 fault flag ", name}, 64'(fault), 64'(e_code != 3'd0));
      if (e_code == 3'd0) begin
         chk(res_paddr == e_pa, {"R7 paddr ", name}, 64'(res_paddr), 64'(e_pa));
         chk(res_pte == (e_lvl ? p1 : p0), {"R7 pte ", name}, 64'(res_pte), 64'(e_lvl ? p1 : p0));
         chk(res_pte_addr == e_pte_addr, {"R7 pte addr ", name}, 64'(res_pte_addr), 64'(e_pte_addr));
         chk(res_level == e_lvl, {"R7 level ", name}, 64'(res_level), 64'(e_lvl));
         chk(res_global == e_glob, {"R8 global ", name}, 64'(res_global), 64'(e_glob));
      end
      @(negedge clk);
      chk(!done, {"R10 done one cycle ", name}, 64'(done), 64'd0);
   endtask

   function automatic logic [31:0] rnd_pte(input bit want_ptr, input bit align);
      logic [31:0] p;
      p = $urandom;
      if (want_ptr) p[3:0] = 4'b0001;
      else begin
         if ($urandom % 8 != 0) p[0] = 1'b1;
         if ($urandom % 4 != 0) p[1] = 1'b1;
      end
      if (align) p[19:10] = 10'd0;
      return p;
   endfunction

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !busy && !mem_req_valid, "R10 reset state",
          64'({done, busy, mem_req_valid}), 64'd0);

      // directed corner cases
      run_case(32'h1234_5678, 34'h0_0040_0000, 2'd0, 1, 0, 0, 0,
               {12'hABC, 10'h000, 2'b00, 8'h23}, 0, 32'h0, 0, "R7 aligned superpage");
      run_case(32'h1234_5678, 34'h0_0040_0000, 2'd0, 1, 0, 0, 0,
               {12'hABC, 10'h001, 2'b00, 8'h03}, 0, 32'h0, 0, "R5 misaligned superpage");
      run_case(32'h1234_5678, 34'h0_0040_0000, 2'd1, 1, 0, 0, 0,
               {12'hABC, 10'h001, 2'b00, 8'h03}, 0, 32'h0, 0, "R6 perm before misalign");
      run_case(32'hFFFF_F123, 34'h3_FFFF_F000, 2'd1, 1, 0, 0, 0,
               {22'h12345, 2'b00, 8'h21}, 0, {22'h3FFFF, 2'b00, 8'h07}, 0, "R2 R8 pointer then leaf");
      run_case(32'h0040_1000, 34'h0_0000_1000, 2'd0, 1, 0, 0, 0,
               {22'h00111, 2'b00, 8'h01}, 0, {22'h00222, 2'b00, 8'h01}, 0, "R4 pointer at level 0");
      run_case(32'h0040_1000, 34'h0_0000_1000, 2'd0, 1, 0, 0, 1,
               {22'h00111, 2'b00, 8'h01}, 0, {22'h00222, 2'b00, 8'h03}, 1, "R3 error on second read");
      run_case(32'h8000_0000, 34'h0_1000_0000, 2'd0, 1, 0, 0, 0,
               32'h0, 1, 32'h0, 0, "R3 error on first read");
      run_case(32'h0000_0000, 34'h0_0000_0000, 2'd1, 1, 0, 0, 0,
               {22'h00400, 2'b00, 8'h05}, 0, 32'h0, 0, "R4 write without read");
      run_case(32'h0000_0000, 34'h0_0000_0000, 2'd0, 1, 0, 0, 0,
               {22'h00400, 2'b00, 8'h0E}, 0, 32'h0, 0, "R4 not valid");
      run_case(32'h0000_0ABC, 34'h0, 2'd0, 1, 0, 0, 0,
               {22'h00400, 2'b00, 8'h13}, 0, 32'h0, 0, "R6 user page no sum");
      run_case(32'h0000_0ABC, 34'h0, 2'd0, 1, 0, 1, 0,
               {22'h00400, 2'b00, 8'h13}, 0, 32'h0, 0, "R6 user page with sum");
      run_case(32'h0000_0ABC, 34'h0, 2'd2, 1, 0, 1, 0,
               {22'h00400, 2'b00, 8'h19}, 0, 32'h0, 0, "R6 user exec from supervisor");
      run_case(32'h0000_0ABC, 34'h0, 2'd0, 1, 1, 0, 0,
               {22'h00400, 2'b00, 8'h09}, 0, 32'h0, 0, "R6 read via mxr");
      run_case(32'h0000_0ABC, 34'h0, 2'd0, 1, 0, 0, 0,
               {22'h00400, 2'b00, 8'h09}, 0, 32'h0, 0, "R6 exec-only read without mxr");
      run_case(32'h0000_0ABC, 34'h0, 2'd0, 0, 0, 0, 0,
               {22'h00400, 2'b00, 8'h03}, 0, 32'h0, 0, "R6 supervisor page in user mode");
      run_case(32'h0000_0ABC, 34'h0, 2'd3, 1, 0, 0, 0,
               {22'h00400, 2'b00, 8'h0F}, 0, 32'h0, 0, "R6 reserved access");

      // constrained random walks
      for (int n = 0; n < 300; n++) begin
         logic [31:0] p1, p0;
         p1 = rnd_pte(($urandom % 5) < 2, ($urandom % 4) != 0);
         p0 = rnd_pte(($urandom % 8) == 0, 1'b0);
         run_case($urandom, {2'($urandom), 32'($urandom)}, 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  p1, ($urandom % 10) == 0, p0, ($urandom % 10) == 0,
                  "R1 R7 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule